// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block is one PWM generator. A single down-counter drives two raw pulse outputs, A and B. Software writes the period (load) value and two compare values into shadow registers. The generator copies them into the active registers only when the counter passes through zero, so a pulse is never cut short or stretched by a write made mid-period.

Two commit policies are available. In immediate mode, pending values take effect at the next zero. In synchronous mode, pending values wait for a global update strobe, which a chip-level controller can pulse to several generators at once. All pending values then switch together at the first zero after that strobe.

Each output has a 12-bit action word that says what happens to it on each counter event. A debug stall input can either halt the counter once it reaches zero, or leave it counting and reloading.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: While rst_ni is low, count_o, pwm_a_o and pwm_b_o are 0. All shadow and active registers are cleared.
- R2: The counter counts down by one per cycle. At zero it reloads from the active load value, so the period is load+1 cycles.
- R3: A write with wr_sel_i 0 targets load, 1 targets compare A, 2 targets compare B, and 3 is ignored. In immediate mode (sync_mode_i=0) a written value is not used until the next counter zero, where it is committed.
- R4: In synchronous mode (sync_mode_i=1), written values stay pending until glob_upd_i has been sampled high. They commit at the first zero that follows the cycle in which the strobe was sampled. A strobe that arrives in the zero cycle itself defers the commit to the next zero.
- R5: In synchronous mode, all pending values commit at the same zero. A repeated write before the commit replaces the earlier shadow value.
- R6: Action word fields: [1:0] on zero, [3:2] on load, [5:4] on compare A counting up, [7:6] on compare A counting down, [9:8] on compare B counting up, [11:10] on compare B counting down. The up fields never fire, because the counter only counts down. Codes: 0 keep, 1 toggle, 2 drive low, 3 drive high. With words 0x08C and 0x80C, A is high for load minus compare A cycles and B is high for load minus compare B cycles of each period.
- R7: An output reacts in the cycle after the counter shows the event value. When the load event and a compare match fall on the same counter value, the load action wins.
- R8: A compare value greater than the load value never matches, so the output stays at its load level for the whole period.
- R9: With stall_run_i=0 and stall_i=1, the counter keeps counting down to zero and then holds at zero. While it holds, nothing is committed. When stall_i is released, it reloads and commits any pending values.
- R10: With stall_run_i=1, stall_i has no effect: the counter keeps counting and reloading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Shadow register write strobe |
| wr_sel_i | input | 2 | Write target: 0 load, 1 compare A, 2 compare B, 3 none |
| wr_data_i | input | CNT_W | Write data |
| sync_mode_i | input | 1 | 0 immediate commit, 1 commit gated by global strobe |
| glob_upd_i | input | 1 | Global update strobe |
| stall_i | input | 1 | Debug stall request |
| stall_run_i | input | 1 | Stall policy: 0 halt at zero, 1 keep running |
| act_a_i | input | 12 | Action word for output A |
| act_b_i | input | 12 | Action word for output B |
| count_o | output | CNT_W | Counter value |
| pwm_a_o | output | 1 | Raw PWM output A |
| pwm_b_o | output | 1 | Raw PWM output B |

## Verification
The following rules are checked by assertions on every cycle:
- the counter steps down by one;
- the counter holds at zero under a halting stall;
- active values never change away from a committing zero;
- in synchronous mode, active values stay frozen while no strobe is armed;
- a high load action always wins.

Some behaviours only the bench scenarios can show:
- the duty cycles for each load/compare pattern;
- that a mid-period write leaves the current period alone;
- that a strobe landing on the zero cycle defers the commit by one period;
- that a repeated write replaces the earlier value;
- that a commit deferred by a halting stall lands on release.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int ACT_W    = 12;
  localparam int NUM_REGS = 3;
  localparam int REG_LOAD = 0;
  localparam int REG_CMPA = 1;
  localparam int REG_CMPB = 2;

  // action word field indices (2 bits each)
  localparam int FLD_ZERO  = 0;
  localparam int FLD_LOAD  = 1;
  localparam int FLD_CA_DN = 3;
  localparam int FLD_CB_DN = 5;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } act_e;

  function automatic logic [1:0] act_field(input logic [ACT_W-1:0] w, input int idx);
    return w[idx*2 +: 2];
  endfunction

  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    case (act_e'(code))
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic             stall_run_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_tick_o,
  output logic             fresh_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fresh_q;
  logic             at_zero;
  logic             halt;
  logic             tick;

  assign at_zero     = (cnt_q == '0);
  assign halt        = stall_i && !stall_run_i && at_zero;
  assign tick        = !halt;
  assign zero_tick_o = tick && at_zero;
  assign cnt_o       = cnt_q;
  assign fresh_o     = fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= tick;
      if (tick) cnt_q <= at_zero ? reload_i : cnt_q - CNT_W'(1);
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !stall_run_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             sync_mode_i,
  input  logic             glob_upd_i,
  input  logic             zero_tick_i,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] act_load_o,
  output logic [CNT_W-1:0] act_cmp_a_o,
  output logic [CNT_W-1:0] act_cmp_b_o
);
  logic             armed_q;
  logic             commit_go;
  logic [CNT_W-1:0] active [NUM_REGS];
  logic [CNT_W-1:0] next_active [NUM_REGS];

  assign commit_go = zero_tick_i && (!sync_mode_i || armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (glob_upd_i) armed_q <= 1'b1;
    else if (zero_tick_i) armed_q <= 1'b0;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;
    logic             pend_q;
    logic             wr_hit;

    assign wr_hit         = wr_en_i && (wr_sel_i == 2'(i));
    assign active[i]      = active_q;
    assign next_active[i] = (commit_go && pend_q) ? shadow_q : active_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        active_q <= '0;
        pend_q   <= 1'b0;
      end else begin
        active_q <= next_active[i];
        if (wr_hit) begin
          shadow_q <= wr_data_i;
          pend_q   <= 1'b1;
        end else if (commit_go) begin
          pend_q   <= 1'b0;
        end
      end
    end
  end

  // counter reloads with the value being committed at this zero
  assign reload_o    = next_active[REG_LOAD];
  assign act_load_o  = active[REG_LOAD];
  assign act_cmp_a_o = active[REG_CMPA];
  assign act_cmp_b_o = active[REG_CMPB];

  // R3
  zero_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zero_tick_i |=> ($stable(act_load_o) && $stable(act_cmp_a_o) && $stable(act_cmp_b_o)));

  // R4
  sync_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && !armed_q) |=> ($stable(act_load_o) && $stable(act_cmp_a_o) && $stable(act_cmp_b_o)));

  // R5
  armed_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_tick_i && armed_q && !glob_upd_i) |=> !armed_q);
endmodule

// File: rtl/pwm_action_unit.sv
module pwm_action_unit
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fresh_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] act_load_i,
  input  logic [CNT_W-1:0] act_cmp_a_i,
  input  logic [CNT_W-1:0] act_cmp_b_i,
  input  logic [ACT_W-1:0] word_i,
  output logic             pwm_o
);
  logic       pwm_q;
  logic       hit_ld, hit_ca, hit_cb, hit_z;
  logic [1:0] c_ld, c_ca, c_cb, c_z;
  logic [1:0] code;

  assign hit_ld = (cnt_i == act_load_i);
  assign hit_ca = (cnt_i == act_cmp_a_i);
  assign hit_cb = (cnt_i == act_cmp_b_i);
  assign hit_z  = (cnt_i == '0);

  assign c_ld = act_field(word_i, FLD_LOAD);
  assign c_ca = act_field(word_i, FLD_CA_DN);
  assign c_cb = act_field(word_i, FLD_CB_DN);
  assign c_z  = act_field(word_i, FLD_ZERO);

  // highest-priority event carrying a non-keep action
  always_comb begin
    if (hit_ld && c_ld != ACT_KEEP)      code = c_ld;
    else if (hit_ca && c_ca != ACT_KEEP) code = c_ca;
    else if (hit_cb && c_cb != ACT_KEEP) code = c_cb;
    else if (hit_z && c_z != ACT_KEEP)   code = c_z;
    else                                 code = ACT_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pwm_q <= 1'b0;
    else if (fresh_i) pwm_q <= apply_act(code, pwm_q);
  end

  assign pwm_o = pwm_q;

  // R7
  load_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fresh_i && hit_ld && c_ld == ACT_HIGH) |=> pwm_o);
endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             sync_mode_i,
  input  logic             glob_upd_i,
  input  logic             stall_i,
  input  logic             stall_run_i,
  input  logic [11:0]      act_a_i,
  input  logic [11:0]      act_b_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pwm_a_o,
  output logic             pwm_b_o
);
  localparam int NUM_OUT = 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] act_load, act_cmp_a, act_cmp_b;
  logic             zero_tick;
  logic             fresh;
  logic [ACT_W-1:0] words [NUM_OUT];
  logic [NUM_OUT-1:0] pwm;

  assign words[0] = act_a_i;
  assign words[1] = act_b_i;

  pwm_shadow_bank #(.CNT_W(CNT_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .sync_mode_i (sync_mode_i),
    .glob_upd_i  (glob_upd_i),
    .zero_tick_i (zero_tick),
    .reload_o    (reload),
    .act_load_o  (act_load),
    .act_cmp_a_o (act_cmp_a),
    .act_cmp_b_o (act_cmp_b)
  );

  pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_i),
    .stall_run_i (stall_run_i),
    .reload_i    (reload),
    .cnt_o       (cnt),
    .zero_tick_o (zero_tick),
    .fresh_o     (fresh)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    pwm_action_unit #(.CNT_W(CNT_W)) u_act (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fresh_i     (fresh),
      .cnt_i       (cnt),
      .act_load_i  (act_load),
      .act_cmp_a_i (act_cmp_a),
      .act_cmp_b_i (act_cmp_b),
      .word_i      (words[g]),
      .pwm_o       (pwm[g])
    );
  end

  assign count_o = cnt;
  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];

  // R1
  rst_out_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && !pwm_a_o && !pwm_b_o));
endmodule

// File: tb/sim_pwm_dbuf_gen.sv
`timescale 1ns/1ps
module sim_pwm_dbuf_gen;
  localparam int CNT_W = 16;
  localparam int NV    = 5;

  typedef struct packed {
    logic [15:0] ld;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [15:0] ha;
    logic [15:0] hb;
  } vec_t;

  // load, cmp A, cmp B, expected high cycles A, B per period
  localparam vec_t VECS [NV] = '{
    '{16'd9,  16'd6,  16'd2, 16'd3,  16'd7 },  // R6 plain duty
    '{16'd9,  16'd0,  16'd9, 16'd9,  16'd10},  // R7 B cmp on load value
    '{16'd4,  16'd4,  16'd1, 16'd5,  16'd3 },  // R7 A cmp on load value
    '{16'd15, 16'd20, 16'd0, 16'd16, 16'd15},  // R8 A cmp beyond load
    '{16'd7,  16'd3,  16'd3, 16'd4,  16'd4 }   // R6 equal compares
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = 2'd0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             sync_mode = 1'b0;
  logic             glob_upd = 1'b0;
  logic             stall = 1'b0;
  logic             stall_run = 1'b0;
  logic [11:0]      act_a = 12'h08C;
  logic [11:0]      act_b = 12'h80C;
  logic [CNT_W-1:0] count;
  logic             pwm_a, pwm_b;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm_dbuf_gen #(.CNT_W(CNT_W)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_sel_i    (wr_sel),
    .wr_data_i   (wr_data),
    .sync_mode_i (sync_mode),
    .glob_upd_i  (glob_upd),
    .stall_i     (stall),
    .stall_run_i (stall_run),
    .act_a_i     (act_a),
    .act_b_i     (act_b),
    .count_o     (count),
    .pwm_a_o     (pwm_a),
    .pwm_b_o     (pwm_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic write_reg(input logic [1:0] sel, input int data);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_for(input int v);
    int n = 0;
    while (int'(count) != v && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (n >= 500) chk(1'b0, "R2 count never reached", int'(count), v);
  endtask

  task automatic measure(input int ld, output int ha, output int hb);
    ha = 0;
    hb = 0;
    for (int i = 0; i <= ld; i++) begin
      @(negedge clk);
      ha += int'(pwm_a);
      hb += int'(pwm_b);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int ha, hb;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1 count", int'(count), 0);
    chk_eq("R1 pwm_a", int'(pwm_a), 0);
    chk_eq("R1 pwm_b", int'(pwm_b), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // duty table, immediate mode
    for (int v = 0; v < NV; v++) begin
      write_reg(2'd0, int'(VECS[v].ld));
      write_reg(2'd1, int'(VECS[v].ca));
      write_reg(2'd2, int'(VECS[v].cb));
      repeat (70) @(negedge clk);
      measure(int'(VECS[v].ld), ha, hb);
      chk_eq($sformatf("R6 vec%0d high A", v), ha, int'(VECS[v].ha));
      chk_eq($sformatf("R6 vec%0d high B", v), hb, int'(VECS[v].hb));
    end

    // R3 mid-period write waits for zero (active load 7)
    wait_for(4);
    write_reg(2'd0, 12);
    chk_eq("R3 no early reload", int'(count), 3);
    wait_for(0);
    @(negedge clk);
    chk_eq("R3 reload at zero", int'(count), 12);

    // R3 select 3 ignored
    write_reg(2'd3, 5);
    wait_for(0);
    @(negedge clk);
    chk_eq("R3 sel3 ignored", int'(count), 12);

    // R4/R5 synchronous mode
    sync_mode = 1'b1;
    write_reg(2'd2, 1);
    write_reg(2'd1, 3);
    write_reg(2'd0, 9);
    write_reg(2'd0, 6);
    wait_for(0);
    @(negedge clk);
    chk_eq("R4 held without strobe", int'(count), 12);
    wait_for(5);
    glob_upd = 1'b1;
    @(negedge clk);
    glob_upd = 1'b0;
    wait_for(0);
    @(negedge clk);
    chk_eq("R5 overwrite then commit", int'(count), 6);
    repeat (20) @(negedge clk);
    measure(6, ha, hb);
    chk_eq("R5 joint commit A", ha, 3);
    chk_eq("R5 joint commit B", hb, 5);

    // R4 strobe in the zero cycle defers one period
    write_reg(2'd0, 8);
    wait_for(0);
    glob_upd = 1'b1;
    @(negedge clk);
    glob_upd = 1'b0;
    chk_eq("R4 strobe on zero deferred", int'(count), 6);
    wait_for(0);
    @(negedge clk);
    chk_eq("R4 commit next zero", int'(count), 8);

    // R9 halt at zero
    sync_mode = 1'b0;
    wait_for(5);
    stall = 1'b1;
    repeat (20) @(negedge clk);
    chk_eq("R9 halted at zero", int'(count), 0);
    write_reg(2'd0, 4);
    repeat (5) @(negedge clk);
    chk_eq("R9 no commit while halted", int'(count), 0);
    stall = 1'b0;
    @(negedge clk);
    chk_eq("R9 commit on release", int'(count), 4);

    // R10 keep running under stall
    stall_run = 1'b1;
    stall = 1'b1;
    wait_for(0);
    @(negedge clk);
    chk_eq("R10 reload during stall", int'(count), 4);
    @(negedge clk);
    chk_eq("R10 counts during stall", int'(count), 3);
    stall = 1'b0;

    finish_run();
  end
endmodule